// File: doc/BRIEF.md
# Prioritized Transmit Buffer Scheduler

This block decides which of several transmit buffers is handed next to a CAN protocol engine. Software marks a buffer as wanting to send and gives it a 2-bit priority. Whenever the engine is idle, the scheduler picks the most urgent waiting buffer and sends the engine a one-cycle start pulse along with the buffer index. It then waits for one of three outcomes: the frame went out, arbitration was lost, or an error frame hit it.

The scheduler keeps four sticky status flags per buffer: sent, arbitration lost, error and aborted. It raises an interrupt for each buffer that has sent its frame and has its interrupt enabled. A buffer that fails is normally offered again. In one-shot mode, or after software has cancelled it, a failed buffer is dropped instead. Software can cancel one buffer or all of them. A buffer that the engine is already carrying is never taken back from it. Frame contents and bit timing are handled elsewhere.

Top module: `tx_sched_top`

## Requirements
- R1: After a synchronous active-low reset, no buffer is pending, all flags are 0, `eng_start` is 0 and `irq` is 0.
- R2: A pulse on `req_set[i]` makes `pend[i]` 1 at the next edge. If the engine is idle and buffer i wins, `eng_start` goes high one edge later for exactly one cycle, with `eng_buf` = i. Each start names a pending buffer.
- R3: Among eligible buffers, the one whose 2-bit field `prio_cfg[2i+1:2i]` holds the largest value is started (3 is most urgent, 0 least).
- R4: When eligible buffers share the largest priority value, the one with the higher index is started.
- R5: While the engine is busy, no new start is issued and `eng_buf` holds its value, even if a more urgent request arrives. That request is started after the current outcome.
- R6: `eng_ok` while busy clears `pend` of the active buffer and sets its `done_flag`. `irq` is 1 exactly when some buffer has both `done_flag` and `int_en` set.
- R7: With `one_shot` = 0 and no cancel, `eng_lost` sets `lost_flag` and `eng_err` sets `err_flag` of the active buffer. The buffer stays pending and is started again on the edge after the idle cycle.
- R8: With `one_shot` = 1, a lost or errored frame sets its `lost_flag` or `err_flag`, clears `pend`, and sets `abt_flag`. It is not started again.
- R9: `abort_req[i]` on a pending buffer that is not with the engine clears `pend[i]` and sets `abt_flag[i]` at the next edge. On the buffer held by the engine, a later success completes normally, while a later failure drops it and sets `abt_flag` in either mode.
- R10: `abort_all` applies the R9 rule to every buffer at once.
- R11: `flag_clr[i]` clears all four flags of buffer i. A flag being set in the same cycle wins over the clear.
- R12: `eng_ok`, `eng_lost` and `eng_err` have no effect while the engine is idle.
- R13: Cancelling a buffer that is not pending leaves its `abt_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set | input | NBUF | One-cycle pulse per buffer to request transmission |
| abort_req | input | NBUF | One-cycle pulse per buffer to cancel its request |
| abort_all | input | 1 | One-cycle pulse cancelling every buffer |
| one_shot | input | 1 | 1: failed frames are not retried |
| prio_cfg | input | NBUF*PRIO_W | Priority field per buffer, buffer i at bits [2i+1:2i] |
| int_en | input | NBUF | Interrupt enable per buffer |
| flag_clr | input | NBUF | Pulse clearing the four flags of a buffer |
| eng_ok | input | 1 | Engine reports the frame was sent |
| eng_lost | input | 1 | Engine reports arbitration lost |
| eng_err | input | 1 | Engine reports an error frame |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_buf | output | IDX_W | Index of the buffer given to the engine |
| pend | output | NBUF | Request bit per buffer |
| done_flag | output | NBUF | Sent flag per buffer |
| lost_flag | output | NBUF | Arbitration-lost flag per buffer |
| err_flag | output | NBUF | Error flag per buffer |
| abt_flag | output | NBUF | Aborted flag per buffer |
| irq | output | 1 | Interrupt, OR of enabled sent flags |

## Verification
The assertions check on every cycle that the winner of each pairwise comparison obeys the priority value and the higher-index tie rule. They also check that a start pulse lasts one cycle and names a pending buffer, that the buffer index holds while the engine is busy, and that each outcome leaves the buffer in the state its mode requires. Other behaviours need a sequence of stimulus and only the bench scenarios show them. These are the ordering across several queued requests, a deferred request being started after the current frame, the difference between cancelling a buffer the engine holds and one it does not, and the interrupt following the enable mask.

// File: rtl/tx_sched_pkg.sv
// Shared types of the transmit scheduler.
package tx_sched_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } sched_st_t;
endpackage

// File: rtl/tx_sched_pick.sv
// Combinational priority selector.
// Picks the eligible buffer with the largest priority value; ties go to the
// higher index. Assumes prio_cfg packs buffer i at bits [i*PW +: PW].
// clk/rst_n are used only by the assertions.
module tx_sched_pick #(
    parameter int NBUF  = 3,
    parameter int PW    = 2,
    parameter int IW    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NBUF-1:0]    elig,
    input  logic [NBUF*PW-1:0] prio_cfg,
    output logic               any,
    output logic [IW-1:0]      win
);
    logic [NBUF-1:0] grant;
    logic [PW-1:0]   best;

    // Linear scan: later (higher) index replaces on ">=" so ties go high.
    always_comb begin
        any  = 1'b0;
        best = '0;
        win  = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (elig[i] && (!any || prio_cfg[i*PW +: PW] >= best)) begin
                any  = 1'b1;
                best = prio_cfg[i*PW +: PW];
                win  = IW'(i);
            end
        end
    end

    // One-hot view of the winner, used by the checks below.
    always_comb begin
        grant = '0;
        if (any) grant[win] = 1'b1;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (any == (elig != '0))) else $error("grant not one-hot"); // R3

    for (genvar i = 0; i < NBUF; i++) begin : g_w
        for (genvar j = 0; j < NBUF; j++) begin : g_l
            if (i > j) begin : g_hi
                AST_TIE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
                    (grant[i] && elig[j]) |-> (prio_cfg[i*PW +: PW] >= prio_cfg[j*PW +: PW]))
                    else $error("tie rule broken"); // R4
            end else if (i < j) begin : g_lo
                AST_PRIO_MAX: assert property (@(posedge clk) disable iff (!rst_n)
                    (grant[i] && elig[j]) |-> (prio_cfg[i*PW +: PW] > prio_cfg[j*PW +: PW]))
                    else $error("priority rule broken"); // R3
            end
        end
    end
endmodule

// File: rtl/tx_sched_slot.sv
// State of one transmit buffer: request bit, cancel mark and four flags.
// Assumes the outcome inputs are already gated to this buffer and to the
// busy engine. Clears of the request win over a new request in one cycle.
module tx_sched_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic kill,
    input  logic in_flight,
    input  logic ev_ok,
    input  logic ev_lost,
    input  logic ev_err,
    input  logic one_shot,
    input  logic clr_flags,
    output logic pend,
    output logic f_done,
    output logic f_lost,
    output logic f_err,
    output logic f_abt
);
    logic mark_q;
    logic ev_fail, ev_any, cancelling, drop_fail, drop_idle;

    always_comb begin
        ev_fail    = (ev_lost | ev_err) & ~ev_ok;
        ev_any     = ev_ok | ev_lost | ev_err;
        cancelling = mark_q | kill;
        drop_fail  = ev_fail & (one_shot | cancelling);
        drop_idle  = kill & ~in_flight & pend;
    end

    // Remember a cancel issued while the engine holds this buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mark_q <= 1'b0;
        else if (!in_flight || ev_any) mark_q <= 1'b0;
        else if (kill)               mark_q <= 1'b1;
    end

    // Request bit: success or dropping clears, otherwise a request sets.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pend <= 1'b0;
        else if (ev_ok || drop_fail)         pend <= 1'b0;
        else if (kill && !in_flight)         pend <= 1'b0;
        else if (set_req)                    pend <= 1'b1;
    end

    // Sticky flags: a set in the same cycle wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_done <= 1'b0;
            f_lost <= 1'b0;
            f_err  <= 1'b0;
            f_abt  <= 1'b0;
        end else begin
            f_done <= (f_done & ~clr_flags) | ev_ok;
            f_lost <= (f_lost & ~clr_flags) | (ev_lost & ~ev_ok);
            f_err  <= (f_err  & ~clr_flags) | (ev_err  & ~ev_ok);
            f_abt  <= (f_abt  & ~clr_flags) | drop_fail | drop_idle;
        end
    end

    AST_OK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ok |=> (!pend && f_done)) else $error("success not retired"); // R6
    AST_ONESHOT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fail && one_shot) |=> (!pend && f_abt)) else $error("one-shot kept"); // R8
    AST_RETRY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fail && !one_shot && !mark_q && !kill) |=> pend) else $error("retry lost"); // R7
    AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !in_flight && pend) |=> (!pend && f_abt)) else $error("cancel missed"); // R9
    AST_CANCEL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !pend && !in_flight && !f_abt) |=> !f_abt) else $error("spurious abort"); // R13
endmodule

// File: rtl/tx_sched_top.sv
// Transmit buffer scheduler top.
// Two-state engine handshake: in IDLE the selector picks a winner among
// pending, non-cancelled buffers and a one-cycle start is issued; in BUSY
// the block waits for one engine outcome, then returns to IDLE for one
// cycle before the next pick. Outcomes while IDLE are ignored.
module tx_sched_top #(
    parameter int NBUF   = 3,
    parameter int PRIO_W = 2,
    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NBUF-1:0]        req_set,
    input  logic [NBUF-1:0]        abort_req,
    input  logic                   abort_all,
    input  logic                   one_shot,
    input  logic [NBUF*PRIO_W-1:0] prio_cfg,
    input  logic [NBUF-1:0]        int_en,
    input  logic [NBUF-1:0]        flag_clr,
    input  logic                   eng_ok,
    input  logic                   eng_lost,
    input  logic                   eng_err,
    output logic                   eng_start,
    output logic [IDX_W-1:0]       eng_buf,
    output logic [NBUF-1:0]        pend,
    output logic [NBUF-1:0]        done_flag,
    output logic [NBUF-1:0]        lost_flag,
    output logic [NBUF-1:0]        err_flag,
    output logic [NBUF-1:0]        abt_flag,
    output logic                   irq
);
    import tx_sched_pkg::*;

    sched_st_t         st_q;
    logic [IDX_W-1:0]  act_q;
    logic              start_q;
    logic              busy, ev_any, any_elig;
    logic [NBUF-1:0]   kill_v, elig;
    logic [IDX_W-1:0]  win;

    // Cancel vector and the set of buffers the selector may consider.
    always_comb begin
        kill_v = abort_req | {NBUF{abort_all}};
        elig   = pend & ~kill_v;
        busy   = (st_q == ST_BUSY);
        ev_any = busy & (eng_ok | eng_lost | eng_err);
    end

    tx_sched_pick #(.NBUF(NBUF), .PW(PRIO_W), .IW(IDX_W)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .elig     (elig),
        .prio_cfg (prio_cfg),
        .any      (any_elig),
        .win      (win)
    );

    // Engine handshake: start on a winner when idle, release on an outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            act_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (!busy) begin
                if (any_elig) begin
                    st_q    <= ST_BUSY;
                    act_q   <= win;
                    start_q <= 1'b1;
                end
            end else if (ev_any) begin
                st_q <= ST_IDLE;
            end
        end
    end

    assign eng_start = start_q;
    assign eng_buf   = act_q;

    for (genvar i = 0; i < NBUF; i++) begin : g_slot
        logic sel;
        assign sel = busy && (act_q == IDX_W'(i));

        tx_sched_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_req   (req_set[i]),
            .kill      (kill_v[i]),
            .in_flight (sel),
            .ev_ok     (sel & eng_ok),
            .ev_lost   (sel & eng_lost),
            .ev_err    (sel & eng_err),
            .one_shot  (one_shot),
            .clr_flags (flag_clr[i]),
            .pend      (pend[i]),
            .f_done    (done_flag[i]),
            .f_lost    (lost_flag[i]),
            .f_err     (err_flag[i]),
            .f_abt     (abt_flag[i])
        );
    end

    // Interrupt: any enabled buffer whose sent flag is up.
    assign irq = |(done_flag & int_en);

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start) else $error("start longer than one cycle"); // R2
    AST_START_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> pend[eng_buf]) else $error("start of empty buffer"); // R2
    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_start) |-> $stable(eng_buf)) else $error("pre-empted"); // R5
    AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (flag_clr == '0)) |=> ((done_flag == $past(done_flag)) &&
        (lost_flag == $past(lost_flag)) && (err_flag == $past(err_flag))))
        else $error("outcome taken while idle"); // R12
endmodule

// File: tb/tb_tx_sched_top.sv
module tb_tx_sched_top;
    localparam int NBUF = 3;
    localparam int PW   = 2;
    localparam int IW   = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NBUF-1:0]   req_set, abort_req, int_en, flag_clr;
    logic              abort_all, one_shot, eng_ok, eng_lost, eng_err;
    logic [NBUF*PW-1:0] prio_cfg;
    logic              eng_start, irq;
    logic [IW-1:0]     eng_buf;
    logic [NBUF-1:0]   pend, done_flag, lost_flag, err_flag, abt_flag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tx_sched_top #(.NBUF(NBUF), .PRIO_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .abort_req(abort_req),
        .abort_all(abort_all), .one_shot(one_shot), .prio_cfg(prio_cfg),
        .int_en(int_en), .flag_clr(flag_clr), .eng_ok(eng_ok),
        .eng_lost(eng_lost), .eng_err(eng_err), .eng_start(eng_start),
        .eng_buf(eng_buf), .pend(pend), .done_flag(done_flag),
        .lost_flag(lost_flag), .err_flag(err_flag), .abt_flag(abt_flag),
        .irq(irq)
    );

    // {p2, p1, p0, request mask, expected first winner}
    localparam logic [10:0] VECS [8] = '{
        {2'd0, 2'd1, 2'd3, 3'b111, 2'd0},
        {2'd2, 2'd3, 2'd0, 3'b111, 2'd1},
        {2'd1, 2'd1, 2'd1, 3'b111, 2'd2},
        {2'd0, 2'd2, 2'd2, 3'b011, 2'd1},
        {2'd3, 2'd0, 2'd0, 3'b101, 2'd2},
        {2'd3, 2'd3, 2'd3, 3'b001, 2'd0},
        {2'd2, 2'd1, 2'd2, 3'b101, 2'd2},
        {2'd0, 2'd2, 2'd1, 3'b111, 2'd1}
    };

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit good, input string rq, input int act, input int exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    task automatic wait_start(output int idx);
        int n = 0;
        while (eng_start !== 1'b1 && n < 40) begin
            tick;
            n++;
        end
        chk(eng_start === 1'b1, "R2 start seen", int'(eng_start), 1);
        idx = int'(eng_buf);
    endtask

    // kind: 0 ok, 1 lost, 2 err
    task automatic respond(input int kind);
        eng_ok   = (kind == 0);
        eng_lost = (kind == 1);
        eng_err  = (kind == 2);
        tick;
        eng_ok = 0; eng_lost = 0; eng_err = 0;
    endtask

    task automatic pulse_req(input logic [NBUF-1:0] m);
        req_set = m;
        tick;
        req_set = '0;
    endtask

    task automatic clear_all;
        flag_clr = '1;
        tick;
        flag_clr = '0;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int idx;
        rst_n = 0; req_set = '0; abort_req = '0; abort_all = 0; one_shot = 0;
        prio_cfg = '0; int_en = '0; flag_clr = '0;
        eng_ok = 0; eng_lost = 0; eng_err = 0;
        repeat (3) tick;
        chk(pend == 0 && done_flag == 0 && lost_flag == 0 && err_flag == 0 &&
            abt_flag == 0 && eng_start == 0 && irq == 0, "R1 reset state",
            int'({pend, done_flag, abt_flag}), 0);
        rst_n = 1;
        tick;

        // Table walk: priority and tie-break (R3, R4), then drain with success.
        for (int v = 0; v < 8; v++) begin
            prio_cfg = VECS[v][10:5];
            pulse_req(VECS[v][4:2]);
            wait_start(idx);
            chk(idx == int'(VECS[v][1:0]), "R3/R4 winner", idx, int'(VECS[v][1:0]));
            respond(0);
            for (int k = 1; k < $countones(VECS[v][4:2]); k++) begin
                wait_start(idx);
                respond(0);
            end
            tick;
            chk(pend == 0 && done_flag == VECS[v][4:2], "R6 drained",
                int'(done_flag), int'(VECS[v][4:2]));
            chk(irq == 0, "R6 irq masked", int'(irq), 0);
            clear_all;
        end

        // R2 timing, R6 interrupt, R11 flag clear
        prio_cfg = '0;
        int_en = 3'b010;
        req_set = 3'b010;
        tick;
        req_set = '0;
        chk(pend == 3'b010 && eng_start == 0, "R2 pending next edge", int'(pend), 2);
        tick;
        chk(eng_start == 1 && eng_buf == 1, "R2 start after one more edge",
            int'(eng_buf), 1);
        tick;
        chk(eng_start == 0, "R2 single-cycle start", int'(eng_start), 0);
        respond(0);
        chk(pend == 0 && done_flag == 3'b010, "R6 success", int'(done_flag), 2);
        chk(irq == 1, "R6 irq enabled", int'(irq), 1);
        flag_clr = 3'b010;
        tick;
        flag_clr = '0;
        chk(done_flag == 0 && irq == 0, "R11 clear", int'(done_flag), 0);
        int_en = '0;

        // R5: no pre-emption
        prio_cfg = {2'd3, 2'd0, 2'd1};
        pulse_req(3'b001);
        wait_start(idx);
        pulse_req(3'b100);
        for (int k = 0; k < 4; k++) begin
            chk(eng_start == 0 && eng_buf == 0, "R5 held", int'(eng_buf), 0);
            tick;
        end
        respond(0);
        wait_start(idx);
        chk(idx == 2, "R5 deferred request next", idx, 2);
        respond(0);
        clear_all;

        // R7: retry in normal mode
        pulse_req(3'b010);
        wait_start(idx);
        respond(1);
        chk(lost_flag == 3'b010 && pend == 3'b010, "R7 lost keeps request",
            int'(pend), 2);
        tick;
        chk(eng_start == 1 && eng_buf == 1, "R7 restarted", int'(eng_start), 1);
        respond(2);
        chk(err_flag == 3'b010 && pend == 3'b010, "R7 error keeps request",
            int'(err_flag), 2);
        wait_start(idx);
        respond(0);
        chk(pend == 0 && done_flag == 3'b010, "R7 finally sent", int'(done_flag), 2);
        clear_all;

        // R8: one-shot
        one_shot = 1;
        pulse_req(3'b100);
        wait_start(idx);
        respond(1);
        chk(pend == 0 && abt_flag == 3'b100 && lost_flag == 3'b100,
            "R8 lost dropped", int'(abt_flag), 4);
        for (int k = 0; k < 3; k++) begin
            tick;
            chk(eng_start == 0, "R8 no retry", int'(eng_start), 0);
        end
        pulse_req(3'b001);
        wait_start(idx);
        respond(2);
        chk(pend == 0 && abt_flag == 3'b101 && err_flag == 3'b001,
            "R8 error dropped", int'(abt_flag), 5);
        one_shot = 0;
        clear_all;

        // R9: cancel while held by engine, then failure
        pulse_req(3'b001);
        wait_start(idx);
        abort_req = 3'b001;
        tick;
        abort_req = '0;
        chk(pend == 3'b001 && abt_flag == 0, "R9 held buffer kept", int'(pend), 1);
        respond(1);
        chk(pend == 0 && abt_flag == 3'b001, "R9 failure after cancel",
            int'(abt_flag), 1);
        clear_all;
        // R9: cancel while held, then success
        pulse_req(3'b010);
        wait_start(idx);
        abort_req = 3'b010;
        tick;
        abort_req = '0;
        respond(0);
        chk(done_flag == 3'b010 && abt_flag == 0 && pend == 0,
            "R9 success after cancel", int'(abt_flag), 0);
        clear_all;
        // R9: cancel of a waiting buffer
        prio_cfg = {2'd3, 2'd0, 2'd0};
        pulse_req(3'b101);
        wait_start(idx);
        chk(idx == 2, "R3 urgent first", idx, 2);
        abort_req = 3'b001;
        tick;
        abort_req = '0;
        chk(pend == 3'b100 && abt_flag == 3'b001, "R9 waiting cancelled",
            int'(pend), 4);
        respond(0);
        repeat (3) tick;
        chk(eng_start == 0 && pend == 0, "R9 cancelled not started", int'(pend), 0);
        clear_all;

        // R10: cancel all
        prio_cfg = {2'd0, 2'd3, 2'd0};
        pulse_req(3'b111);
        wait_start(idx);
        chk(idx == 1, "R10 setup winner", idx, 1);
        abort_all = 1;
        tick;
        abort_all = 0;
        chk(pend == 3'b010 && abt_flag == 3'b101, "R10 waiting cancelled",
            int'(abt_flag), 5);
        respond(0);
        chk(pend == 0 && done_flag == 3'b010 && abt_flag == 3'b101,
            "R10 held buffer completes", int'(done_flag), 2);
        clear_all;

        // R12: outcomes while idle
        eng_ok = 1; eng_lost = 1; eng_err = 1;
        tick;
        eng_ok = 0; eng_lost = 0; eng_err = 0;
        tick;
        chk(done_flag == 0 && lost_flag == 0 && err_flag == 0 && eng_start == 0,
            "R12 idle outcomes ignored", int'({done_flag, lost_flag, err_flag}), 0);

        // R13: cancel of empty buffers
        abort_req = 3'b111;
        tick;
        abort_req = '0;
        abort_all = 1;
        tick;
        abort_all = 0;
        chk(abt_flag == 0 && pend == 0, "R13 no abort flag", int'(abt_flag), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule